// File: doc/BRIEF.md
# Dual-Page Streaming Histogram

This block counts how often each value range occurs in a sample stream. The stream carries a valid flag, a sync flag and a data word. The upper bits of each valid data word select a bin, and that bin's count goes up by one. Counting restarts at every sync. The result of the interval that just ended stays readable until the next sync.

The counts live in two pages. One page collects the interval in progress. The other holds the last completed interval and is served to a small memory-mapped read port. A valid sample with sync set swaps the roles of the two pages. The very first such sample after reset only arms counting. Once a reader has had its chance, a background sweep zeroes the held page, so that page starts empty when it next becomes the counting page. A reader should begin a full copy about ten cycles after sync and finish it before the sweep starts.

Top module: `hist_dual_page`

## Requirements
- R1: A sample with in_valid=1 and in_sync=1 swaps the counting and held pages. The first such sample after reset does not swap; it only starts counting. Until the first swap, every bin of the held page reads 0.
- R2: The bin index is in_data[DATA_W-1 -: ADDR_W] as an unsigned number, where ADDR_W = $clog2(NUM_BINS). Each counted sample adds exactly one to its bin in the counting page.
- R3: Each count is $clog2(SAMPLES_PER_SYNC+1) bits wide. A bin that receives all SAMPLES_PER_SYNC samples of one interval reads back that full value, with no wrap.
- R4: A read strobe rd_en=1 with rd_addr, sampled at a clock edge, returns rd_valid=1 and the held-page count of that address after the next edge. rd_valid is 0 in a cycle that follows no strobe. Strobes may be issued back to back, one address per cycle.
- R5: Consecutive valid samples that hit the same bin in consecutive cycles are each counted. No increment is lost to the read-modify-write latency.
- R6: A sample with in_valid=0 changes no count and does not swap pages, even when in_sync=1.
- R7: The sample that carries the sync flag is counted in the interval it opens.
- R8: After a swap, held-page reads issued from 10 cycles after the sync sample up to CLR_DELAY cycles after it return the completed interval's counts. Reads issued from CLR_DELAY+NUM_BINS+2 cycles after the swap until the next sync return 0.
- R9: During reset and after it, rd_valid is 0. For NUM_BINS cycles after reset is released, both pages are zeroed and every input sample, including a sync, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_sync | input | 1 | Interval start flag on the current sample |
| in_data | input | DATA_W | Sample word; its upper ADDR_W bits select the bin |
| rd_en | input | 1 | Read strobe for the held page |
| rd_addr | input | ADDR_W | Bin address to read |
| rd_data | output | CNT_W | Held-page count, one cycle after the strobe |
| rd_valid | output | 1 | Marks rd_data as valid |

## Verification
The first counted interval uses random valid gaps and random data. Invalid samples in it carry a random sync flag, which checks that bin selection and counting match a reference count. The second interval sends its whole sample budget back to back into the top bin; this catches lost increments in the forwarding path and any wrap at the count limit. A third interval alternates repeated bins with invalid sync-flagged samples, which separates correct gating from spurious swaps. An idle interval with only a sync sample isolates whether the sync sample is counted in the interval it opens. Every interval is read twice: once early, to check the completed counts, and once late, to check that the sweep has zeroed them. Syncs sent during the start-up sweep check that they are ignored.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_WAIT  = 2'd1,
    SW_CLEAR = 2'd2
  } sweep_state_e;

  // Width of a counter that can reach n without wrapping.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hist_page_ram.sv
module hist_page_ram #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [CNT_W-1:0]  qa,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [CNT_W-1:0]  qb
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0] mem [DEPTH];

  // One write port, two registered read ports; a read at the writing edge sees old data.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    qa <= mem[raddr_a];
  end

  always_ff @(posedge clk) begin
    qb <= mem[raddr_b];
  end

endmodule

// File: rtl/hist_count_pipe.sv
module hist_count_pipe #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_vld,
  input  logic [ADDR_W-1:0]     s_bin,
  input  logic                  s_page,
  input  logic [1:0][CNT_W-1:0] q_page,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic                  wr_page,
  output logic [CNT_W-1:0]      wr_data
);
  // Stage A: the RAM read is in flight; stage B: the write just issued.
  logic              a_vld, b_vld;
  logic [ADDR_W-1:0] a_bin, b_bin;
  logic              a_page, b_page;
  logic [CNT_W-1:0]  b_cnt;
  logic [CNT_W-1:0]  base;
  logic              hit_b;

  always_comb begin
    hit_b   = b_vld && (b_bin == a_bin) && (b_page == a_page);
    base    = hit_b ? b_cnt : q_page[a_page];
    wr_en   = a_vld;
    wr_addr = a_bin;
    wr_page = a_page;
    wr_data = base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld  <= 1'b0;
      a_bin  <= '0;
      a_page <= 1'b0;
      b_vld  <= 1'b0;
      b_bin  <= '0;
      b_page <= 1'b0;
      b_cnt  <= '0;
    end else begin
      a_vld  <= s_vld;
      a_bin  <= s_bin;
      a_page <= s_page;
      b_vld  <= a_vld;
      b_bin  <= a_bin;
      b_page <= a_page;
      b_cnt  <= wr_data;
    end
  end

endmodule

// File: rtl/hist_page_ctrl.sv
module hist_page_ctrl
  import hist_pkg::*;
#(
  parameter int NUM_BINS  = 16,
  parameter int ADDR_W    = 4,
  parameter int CLR_DELAY = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sync,
  output logic              accept,
  output logic              sample_page,
  output logic              acc_page,
  output logic              init_busy,
  output logic              sweep_we,
  output logic [1:0]        sweep_mask,
  output logic [ADDR_W-1:0] sweep_addr
);
  localparam int DLY_W = $clog2(CLR_DELAY + 1);
  localparam logic [ADDR_W-1:0] LAST_BIN = ADDR_W'(NUM_BINS - 1);
  localparam logic [DLY_W-1:0]  DLY_END  = DLY_W'(CLR_DELAY - 1);

  sweep_state_e     st;
  logic             started;
  logic             sync_hit;
  logic             swap;
  logic [DLY_W-1:0] dly;

  always_comb begin
    sync_hit    = in_valid && in_sync && !init_busy;
    swap        = started && sync_hit;
    accept      = in_valid && !init_busy && (started || in_sync);
    sample_page = swap ? ~acc_page : acc_page;
    sweep_we    = (st == SW_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SW_CLEAR;
      init_busy  <= 1'b1;
      sweep_mask <= 2'b11;
      sweep_addr <= '0;
      started    <= 1'b0;
      acc_page   <= 1'b0;
      dly        <= '0;
    end else begin
      if (sync_hit) started <= 1'b1;
      if (swap)     acc_page <= ~acc_page;
      unique case (st)
        SW_IDLE: begin
          if (swap) begin
            st  <= SW_WAIT;
            dly <= '0;
          end
        end
        SW_WAIT: begin
          if (swap) begin
            dly <= '0;
          end else if (dly == DLY_END) begin
            st         <= SW_CLEAR;
            sweep_addr <= '0;
            sweep_mask <= acc_page ? 2'b01 : 2'b10;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        SW_CLEAR: begin
          if (sweep_addr == LAST_BIN) begin
            init_busy <= 1'b0;
            st        <= swap ? SW_WAIT : SW_IDLE;
            dly       <= '0;
          end else begin
            sweep_addr <= sweep_addr + 1'b1;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hist_dual_page.sv
module hist_dual_page
  import hist_pkg::*;
#(
  parameter int DATA_W           = 8,
  parameter int NUM_BINS         = 16,
  parameter int SAMPLES_PER_SYNC = 64,
  parameter int CLR_DELAY        = 40
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic                                  in_sync,
  input  logic [DATA_W-1:0]                     in_data,
  input  logic                                  rd_en,
  input  logic [$clog2(NUM_BINS)-1:0]           rd_addr,
  output logic [$clog2(SAMPLES_PER_SYNC+1)-1:0] rd_data,
  output logic                                  rd_valid
);
  localparam int ADDR_W = $clog2(NUM_BINS);
  localparam int CNT_W  = count_width(SAMPLES_PER_SYNC);

  logic              accept, sample_page, acc_page, init_busy;
  logic              sweep_we;
  logic [1:0]        sweep_mask;
  logic [ADDR_W-1:0] sweep_addr;
  logic [ADDR_W-1:0] s_bin;

  logic              cnt_we, cnt_wpage;
  logic [ADDR_W-1:0] cnt_waddr;
  logic [CNT_W-1:0]  cnt_wdata;

  logic [1:0][CNT_W-1:0] qa, qb;
  logic                  rd_sel;

  assign s_bin = in_data[DATA_W-1 -: ADDR_W];

  generate
    if (DATA_W > ADDR_W) begin : g_low_bits
      logic unused_low;
      assign unused_low = ^in_data[DATA_W-ADDR_W-1:0];
    end
  endgenerate

  hist_page_ctrl #(
    .NUM_BINS  (NUM_BINS),
    .ADDR_W    (ADDR_W),
    .CLR_DELAY (CLR_DELAY)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sync     (in_sync),
    .accept      (accept),
    .sample_page (sample_page),
    .acc_page    (acc_page),
    .init_busy   (init_busy),
    .sweep_we    (sweep_we),
    .sweep_mask  (sweep_mask),
    .sweep_addr  (sweep_addr)
  );

  hist_count_pipe #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .s_vld   (accept),
    .s_bin   (s_bin),
    .s_page  (sample_page),
    .q_page  (qa),
    .wr_en   (cnt_we),
    .wr_addr (cnt_waddr),
    .wr_page (cnt_wpage),
    .wr_data (cnt_wdata)
  );

  generate
    for (genvar p = 0; p < 2; p++) begin : g_page
      logic              we;
      logic [ADDR_W-1:0] wa;
      logic [CNT_W-1:0]  wd;

      always_comb begin
        if (sweep_we && sweep_mask[p]) begin
          we = 1'b1;
          wa = sweep_addr;
          wd = '0;
        end else begin
          we = cnt_we && (cnt_wpage == 1'(p));
          wa = cnt_waddr;
          wd = cnt_wdata;
        end
      end

      hist_page_ram #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
      ) u_ram (
        .clk     (clk),
        .we      (we),
        .waddr   (wa),
        .wdata   (wd),
        .raddr_a (s_bin),
        .qa      (qa[p]),
        .raddr_b (rd_addr),
        .qb      (qb[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_sel   <= 1'b1;
    end else begin
      rd_valid <= rd_en;
      rd_sel   <= ~acc_page;
    end
  end

  assign rd_data = qb[rd_sel];

endmodule

// File: rtl/hist_dual_page_checker.sv
module hist_dual_page_checker #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sync,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              acc_page,
  input logic              cnt_we,
  input logic [ADDR_W-1:0] cnt_waddr,
  input logic              cnt_wpage,
  input logic [CNT_W-1:0]  cnt_wdata,
  input logic              sweep_we,
  input logic [1:0]        sweep_mask,
  input logic              init_busy
);

  assert_rd_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_rd_valid_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_we |-> (cnt_wdata != '0));

  assert_forward_chain_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_we && $past(cnt_we) && (cnt_waddr == $past(cnt_waddr)) &&
     (cnt_wpage == $past(cnt_wpage)))
    |-> (cnt_wdata == CNT_W'($past(cnt_wdata) + 1'b1)));

  assert_swap_on_sync_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc_page) |-> $past(in_valid && in_sync));

  assert_clear_held_only_R8: assert property (@(posedge clk) disable iff (rst)
    (sweep_we && !init_busy) |-> !sweep_mask[acc_page]);

endmodule

bind hist_dual_page hist_dual_page_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sync    (in_sync),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .acc_page   (acc_page),
  .cnt_we     (cnt_we),
  .cnt_waddr  (cnt_waddr),
  .cnt_wpage  (cnt_wpage),
  .cnt_wdata  (cnt_wdata),
  .sweep_we   (sweep_we),
  .sweep_mask (sweep_mask),
  .init_busy  (init_busy)
);

// File: tb/hist_dual_page_test.sv
`timescale 1ns/1ps
module hist_dual_page_test;
  localparam int DATA_W   = 8;
  localparam int NUM_BINS = 16;
  localparam int SPS      = 64;
  localparam int CLR_DLY  = 40;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = 7;
  localparam int IVL      = 80;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_sync = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CNT_W-1:0]  rd_data;
  logic              rd_valid;

  int checks = 0;
  int errors = 0;
  int cur [NUM_BINS];
  int held_exp [NUM_BINS];
  bit started_m = 1'b0;

  always #2 clk = ~clk;

  hist_dual_page #(
    .DATA_W (DATA_W), .NUM_BINS (NUM_BINS),
    .SAMPLES_PER_SYNC (SPS), .CLR_DELAY (CLR_DLY)
  ) uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_sync (in_sync),
    .in_data (in_data), .rd_en (rd_en), .rd_addr (rd_addr),
    .rd_data (rd_data), .rd_valid (rd_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model of one sample: applies R1, R2, R6, R7.
  task automatic model_sample(input bit v, input bit s, input logic [DATA_W-1:0] d);
    if (!v) return;
    if (s) begin
      if (started_m) begin
        for (int b = 0; b < NUM_BINS; b++) begin
          held_exp[b] = cur[b];
          cur[b] = 0;
        end
      end
      started_m = 1'b1;
    end
    if (started_m) cur[d[DATA_W-1 -: ADDR_W]]++;
  endtask

  task automatic drive_interval(input int kind);
    int nvalid = 0;
    for (int c = 0; c < IVL; c++) begin
      bit v, s;
      logic [DATA_W-1:0] d;
      d = DATA_W'($urandom);
      s = 1'b0;
      if (c == 0) begin
        v = 1'b1; s = 1'b1;
        if (kind == 2) d = 8'hF3;
        if (kind == 4) d = 8'h9C;
      end else begin
        case (kind)
          2: begin v = 1'b1; d = {4'hF, 4'(c)}; end
          3: begin
            if (c % 4 == 0) begin v = 1'b0; s = 1'b1; end
            else begin
              v = 1'b1;
              d = ((c / 4) % 2 == 1) ? 8'h35 : {4'(c), 4'h0};
            end
          end
          4: v = 1'b0;
          default: begin
            v = ($urandom % 3) != 0;
            if (!v) s = 1'($urandom);
          end
        endcase
      end
      if (v && nvalid >= SPS) v = 1'b0;
      if (v) nvalid++;
      in_valid = v; in_sync = s; in_data = d;
      model_sample(v, s, d);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sync = 1'b0;
  endtask

  task automatic read_all(input bit zero_exp, input string req);
    for (int a = 0; a < NUM_BINS; a++) begin
      int e;
      rd_en = 1'b1;
      rd_addr = ADDR_W'(a);
      @(negedge clk);
      e = zero_exp ? 0 : held_exp[a];
      check(rd_valid == 1'b1, "R4", int'(rd_valid), 1);
      check(int'(rd_data) == e, req, int'(rd_data), e);
    end
    rd_en = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R4", int'(rd_valid), 0);
  endtask

  task automatic run_interval(input int kind, input bit held_zero, input string req);
    fork
      drive_interval(kind);
      begin
        repeat (12) @(negedge clk);
        read_all(held_zero, req);
        repeat (33) @(negedge clk);
        read_all(1'b1, "R8");
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < NUM_BINS; b++) begin
      cur[b] = 0;
      held_exp[b] = 0;
    end
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R9", int'(rd_valid), 0);
    rst = 1'b0;
    check(rd_valid == 1'b0, "R9", int'(rd_valid), 0);
    // R9: syncs during the start-up sweep are ignored (model does not see them).
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_sync = 1'b1; in_data = 8'h50;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sync = 1'b0;
    repeat (20) @(negedge clk);
    // R1: held page zero before any sync
    read_all(1'b1, "R1");
    // First sync: starts counting, held page still zero (R1)
    run_interval(0, 1'b1, "R1");
    // Random interval; readback checks R2 and R7 on the first interval
    run_interval(1, 1'b0, "R2");
    // All samples into bin 15 back to back: readback checks previous random interval (R2)
    run_interval(2, 1'b0, "R2");
    // Invalid samples with sync: readback checks bin 15 = 64 (R3, R5)
    run_interval(3, 1'b0, "R3_R5");
    // Idle interval: readback checks the mixed interval (R6)
    run_interval(4, 1'b0, "R6");
    // Final idle interval: only the sync sample of the previous one counted (R7)
    check(held_exp[0] == 0, "R7", held_exp[0], 0);
    run_interval(4, 1'b0, "R7");
    check(held_exp[9] == 1, "R7", held_exp[9], 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule